// File: doc/BRIEF.md
# Two-Stage I2C Bit-Rate Generator

This block turns a fast system clock into the timing reference for an I2C master. A packed 7-bit rate setting holds a linear prescale field M and an exponent field N. The clock is divided first by M+1 and then by a power of two. The result is an oversampling tick at ten times the SCL rate. A final divide-by-ten stage then splits each SCL period into a low half and a high half of five ticks each. In the standard build the SCL frequency is Fclk / (10·(M+1)·2^(N+1)). A build parameter selects the variant in which the exponent stage divides by 2^N.

The controlling engine loads the setting through a single-cycle write strobe. Every write, and every soft reset, clears all divider counters, so the new rate starts with a full period and with SCL low. Software searches for the M/N pair that suits a target bus speed. The divider counts only while the engine enable is high. While the enable is low its counters are held at zero.

Top module: `scl_rate_gen`

## Requirements
- R1: While reset is asserted, and right after it, the rate setting reads 0x44 (M=8, N=4), `tick` and `scl_toggle` are low, and `scl_phase` is low.
- R2: The rate setting carries M in bits [6:3] and N in bits [2:0]. With the standard exponent (EXP_BIAS=1), `tick` is a one-cycle pulse every (M+1)·2^(N+1) clocks. In cycle n after a restart (n=0 is the first counting cycle), `tick` is high exactly when n mod P equals P−1.
- R3: With the variant exponent (EXP_BIAS=0), the tick period is (M+1)·2^N clocks, with the same alignment as R2. For M=0 and N=0 this is a tick in every cycle.
- R4: Each SCL period spans 10 ticks. `scl_phase` is 0 for tick slots 0–4 and 1 for slots 5–9. In cycle n the slot is floor(n/P) mod 10. `scl_toggle` is high in the tick cycle that closes slot 4 or slot 9, which is the cycle just before `scl_phase` changes.
- R5: A write (`cfg_we` high) clears every divider counter. The new rate starts at n=0 in the cycle after the write, with `scl_phase` low.
- R6: `soft_rst` restores the setting to 0x44 and clears the counters the same way as a write. It takes priority over a write in the same cycle.
- R7: While `enable` is low, no tick or toggle is produced, the counters are cleared from the following cycle on, `scl_phase` is low from then on, and the setting is kept. When `enable` rises, counting restarts at n=0.
- R8: `cfg_q` shows the last written value from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Engine enable; counters are held cleared while low |
| soft_rst | input | 1 | Synchronous restore of the default setting |
| cfg_we | input | 1 | Write strobe for the rate setting |
| cfg_wdata | input | 7 | New setting, M in [6:3], N in [2:0] |
| cfg_q | output | 7 | Current rate setting |
| tick | output | 1 | Oversampling pulse, ten per SCL period |
| scl_phase | output | 1 | SCL half: 0 low, 1 high |
| scl_toggle | output | 1 | Pulse in the cycle before scl_phase flips |

## Verification
The bench builds two copies side by side with default widths: one with the standard exponent and one with EXP_BIAS=0. Both see the same stimulus, so every setting tests both formulas at once. Every M value is swept with N=0, and every N value with M=0. The sweep adds a mid-range pair, the slowest setting 0x7F and the reset default. It reaches the extremes where the variant ticks every cycle and where the exponent counter uses its full width. Every cycle of each window is compared against tick and phase predicted from n, P and the R4 slot formula. Further windows cover resumption after enable is dropped and a soft reset that collides with a write.

// File: rtl/srg_pkg.sv
package srg_pkg;
   localparam int unsigned SRG_M_W     = 4;
   localparam int unsigned SRG_N_W     = 3;
   localparam int unsigned SRG_OVERS   = 10;
   localparam logic [6:0]  SRG_DEFAULT = 7'h44;
endpackage

// File: rtl/srg_prescale.sv
module srg_prescale #(
   parameter int unsigned M_W = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic [M_W-1:0] m_val,
   output logic           pre_done
);
   logic [M_W-1:0] cnt;
   logic           at_end;

   assign at_end   = (cnt == m_val);
   assign pre_done = ~clr & at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clr)    cnt <= '0;
      else if (at_end) cnt <= '0;
      else             cnt <= cnt + 1'b1;
   end

   // R2: linear count never passes the programmed M
   a_r2_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= m_val);
endmodule

// File: rtl/srg_pow2.sv
module srg_pow2 #(
   parameter int unsigned N_W      = 3,
   parameter int unsigned EXP_BIAS = 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           step,
   input  logic [N_W-1:0] n_val,
   output logic           tick
);
   localparam int unsigned Q_W = (1 << N_W) - 1 + EXP_BIAS;

   logic [N_W:0]   expo;
   logic [Q_W-1:0] lim;
   logic [Q_W-1:0] cnt;
   logic           at_end;

   generate
      if (EXP_BIAS == 1) begin : g_exp_plus1
         assign expo = {1'b0, n_val} + 1'b1;
      end else begin : g_exp_plain
         assign expo = {1'b0, n_val};
      end
   endgenerate

   assign lim    = ~({Q_W{1'b1}} << expo);
   assign at_end = (cnt == lim);
   assign tick   = step & at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (step) cnt <= at_end ? '0 : cnt + 1'b1;
   end

   // R2: exponent counter stays inside its window
   a_r2_pow_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= lim);
   // R2: a tick only on a prescaler completion
   a_r2_tick_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> step);
endmodule

// File: rtl/srg_decade.sv
module srg_decade #(
   parameter int unsigned OVERS = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   output logic scl_phase,
   output logic scl_toggle
);
   localparam int unsigned D_W  = $clog2(OVERS);
   localparam int unsigned HALF = OVERS / 2;

   logic [D_W-1:0] slot;
   logic           last_slot;

   assign last_slot  = (slot == D_W'(OVERS - 1));
   assign scl_phase  = (slot >= D_W'(HALF));
   assign scl_toggle = tick & (last_slot | (slot == D_W'(HALF - 1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    slot <= '0;
      else if (clr)  slot <= '0;
      else if (tick) slot <= last_slot ? '0 : slot + 1'b1;
   end

   // R4: slot index stays below the oversampling count
   a_r4_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
      slot < D_W'(OVERS));
   // R4: the phase moves only on a tick
   a_r4_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !tick) |=> $stable(scl_phase));
   // R4: every flip of the phase is announced by a toggle
   a_r4_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && scl_toggle) |=> (scl_phase != $past(scl_phase)));
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
   import srg_pkg::*;
#(
   parameter int unsigned M_W       = SRG_M_W,
   parameter int unsigned N_W       = SRG_N_W,
   parameter int unsigned OVERS     = SRG_OVERS,
   parameter int unsigned EXP_BIAS  = 1,
   parameter logic [M_W+N_W-1:0] CFG_RESET = SRG_DEFAULT
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               soft_rst,
   input  logic               cfg_we,
   input  logic [M_W+N_W-1:0] cfg_wdata,
   output logic [M_W+N_W-1:0] cfg_q,
   output logic               tick,
   output logic               scl_phase,
   output logic               scl_toggle
);
   localparam int unsigned CFG_W = M_W + N_W;

   generate
      if (M_W < 1 || M_W > 8) begin : g_bad_m
         $error("M_W must lie in 1..8");
      end
      if (N_W < 1 || N_W > 4) begin : g_bad_n
         $error("N_W must lie in 1..4");
      end
      if (OVERS < 2 || (OVERS % 2) != 0) begin : g_bad_overs
         $error("OVERS must be even and at least 2");
      end
      if (EXP_BIAS > 1) begin : g_bad_bias
         $error("EXP_BIAS must be 0 or 1");
      end
   endgenerate

   logic [CFG_W-1:0] cfg_r;
   logic             clr;
   logic             pre_done;

   assign clr   = ~enable | cfg_we | soft_rst;
   assign cfg_q = cfg_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cfg_r <= CFG_RESET;
      else if (soft_rst) cfg_r <= CFG_RESET;
      else if (cfg_we)   cfg_r <= cfg_wdata;
   end

   srg_prescale #(.M_W(M_W)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .m_val    (cfg_r[CFG_W-1:N_W]),
      .pre_done (pre_done)
   );

   srg_pow2 #(.N_W(N_W), .EXP_BIAS(EXP_BIAS)) u_pow (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .step  (pre_done),
      .n_val (cfg_r[N_W-1:0]),
      .tick  (tick)
   );

   srg_decade #(.OVERS(OVERS)) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .tick       (tick),
      .scl_phase  (scl_phase),
      .scl_toggle (scl_toggle)
   );

   // R7: no timing pulses while the engine is off
   a_r7_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (!tick && !scl_toggle));
   // R7: the setting survives a disabled period
   a_r7_cfg_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !cfg_we && !soft_rst) |=> $stable(cfg_q));
   // R6: soft reset restores the default and restarts low
   a_r6_default_restore: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (cfg_q == CFG_RESET && !scl_phase));
   // R5: a write restarts the SCL period in its low half
   a_r5_restart_low: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> !scl_phase);
endmodule

// File: tb/scl_rate_gen_tb.sv
`timescale 1ns/1ps
module scl_rate_gen_tb;
   logic       clk = 1'b0;
   logic       rst_n, enable, soft_rst, cfg_we;
   logic [6:0] cfg_wdata;
   logic [6:0] q_main, q_alt;
   logic       tk_main, ph_main, tg_main;
   logic       tk_alt, ph_alt, tg_alt;

   int n_chk = 0;
   int n_bad = 0;
   int p_main, p_alt;
   bit done = 0;

   always #4 clk = ~clk;

   scl_rate_gen u_dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .soft_rst(soft_rst),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(q_main),
      .tick(tk_main), .scl_phase(ph_main), .scl_toggle(tg_main));

   scl_rate_gen #(.EXP_BIAS(0)) u_dut_alt (
      .clk(clk), .rst_n(rst_n), .enable(enable), .soft_rst(soft_rst),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(q_alt),
      .tick(tk_alt), .scl_phase(ph_alt), .scl_toggle(tg_alt));

   task automatic check(input bit ok, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic set_periods(input logic [6:0] v);
      int m = int'(v[6:3]);
      int n = int'(v[2:0]);
      p_main = (m + 1) << (n + 1);
      p_alt  = (m + 1) << n;
   endtask

   function automatic int exp_tick(input int n, input int p);
      return ((n % p) == p - 1) ? 1 : 0;
   endfunction

   function automatic int exp_phase(input int n, input int p);
      return (((n / p) % 10) >= 5) ? 1 : 0;
   endfunction

   function automatic int exp_tog(input int n, input int p);
      int s = (n / p) % 10;
      return (exp_tick(n, p) == 1 && (s == 4 || s == 9)) ? 1 : 0;
   endfunction

   // first sample taken now (cycle 0), then one per falling edge
   task automatic observe(input int len, input string lbl);
      int bt_m = 0, bp_m = 0, bt_a = 0, bp_a = 0;
      int at_m = 0, et_m = 0, ap_m = 0, ep_m = 0;
      int at_a = 0, et_a = 0, ap_a = 0, ep_a = 0;
      for (int n = 0; n < len; n++) begin
         if (n > 0) begin
            @(negedge clk);
            #1;
         end
         if (int'(tk_main) != exp_tick(n, p_main)) begin
            if (bt_m == 0) begin at_m = int'(tk_main); et_m = exp_tick(n, p_main); end
            bt_m++;
         end
         if (int'(tk_alt) != exp_tick(n, p_alt)) begin
            if (bt_a == 0) begin at_a = int'(tk_alt); et_a = exp_tick(n, p_alt); end
            bt_a++;
         end
         if (int'(ph_main) != exp_phase(n, p_main) || int'(tg_main) != exp_tog(n, p_main)) begin
            if (bp_m == 0) begin
               ap_m = 2 * int'(ph_main) + int'(tg_main);
               ep_m = 2 * exp_phase(n, p_main) + exp_tog(n, p_main);
            end
            bp_m++;
         end
         if (int'(ph_alt) != exp_phase(n, p_alt) || int'(tg_alt) != exp_tog(n, p_alt)) begin
            if (bp_a == 0) begin
               ap_a = 2 * int'(ph_alt) + int'(tg_alt);
               ep_a = 2 * exp_phase(n, p_alt) + exp_tog(n, p_alt);
            end
            bp_a++;
         end
      end
      check(bt_m == 0, {"R2 tick pattern, standard, ", lbl}, at_m, et_m);
      check(bt_a == 0, {"R3 tick pattern, variant, ", lbl}, at_a, et_a);
      check(bp_m == 0, {"R4 phase/toggle, standard, ", lbl}, ap_m, ep_m);
      check(bp_a == 0, {"R4 phase/toggle, variant, ", lbl}, ap_a, ep_a);
   endtask

   task automatic write_cfg(input logic [6:0] v);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
      #1;
      set_periods(v);
      check(q_main == v && q_alt == v, "R8 readback after write", int'(q_main), int'(v));
   endtask

   initial begin
      rst_n = 1'b0; enable = 1'b0; soft_rst = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
      repeat (3) @(negedge clk);
      #1;
      check(q_main == 7'h44 && q_alt == 7'h44, "R1 reset setting", int'(q_main), 68);
      check(!tk_main && !tg_main && !tk_alt && !tg_alt, "R1 reset pulses low",
            int'(tk_main) + int'(tg_main), 0);
      check(!ph_main && !ph_alt, "R1 reset phase low", int'(ph_main), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      enable = 1'b1;
      #1;
      set_periods(7'h44);
      observe(20 * p_main, "R1 default after reset");

      // R7: drop enable mid-period
      begin
         int bad = 0;
         repeat (37) @(negedge clk);
         enable = 1'b0;
         for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            #1;
            if (tk_main || tg_main || ph_main || tk_alt || tg_alt || ph_alt) bad++;
         end
         check(bad == 0, "R7 outputs quiet while disabled", bad, 0);
         check(q_main == 7'h44, "R7 setting kept while disabled", int'(q_main), 68);
         @(negedge clk);
         enable = 1'b1;
         #1;
         observe(20 * p_main, "R7 resume after enable");
      end

      // R5: writes during running operation, M sweep then N sweep
      for (int m = 0; m < 16; m++) begin
         write_cfg(7'((m << 3) | 0));
         observe(20 * p_main, $sformatf("R5 M sweep m=%0d", m));
      end
      for (int n = 0; n < 8; n++) begin
         write_cfg(7'(n));
         observe(20 * p_main, $sformatf("R5 N sweep n=%0d", n));
      end
      write_cfg(7'h1D);
      observe(20 * p_main, "R5 M=3 N=5");
      write_cfg(7'h7F);
      observe(12 * p_main, "R5 slowest setting");

      // R6: soft reset collides with a write
      @(negedge clk);
      soft_rst = 1'b1;
      cfg_we = 1'b1;
      cfg_wdata = 7'h2A;
      @(negedge clk);
      soft_rst = 1'b0;
      cfg_we = 1'b0;
      #1;
      check(q_main == 7'h44 && q_alt == 7'h44, "R6 soft reset beats write",
            int'(q_main), 68);
      set_periods(7'h44);
      observe(20 * p_main, "R6 after soft reset");

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule